// File: doc/BRIEF.md
# Predicated Condition Evaluation Unit

This unit decides, instruction by instruction, whether a result may be committed to its destination. It reads a 4-bit condition field from the decoded instruction. A 2-bit selector in that field picks one test source. By default the sources are the stored carry, sign and zero flags, plus a constant true. When the field's source-switch bit is set, the same selector instead picks one of four external test bits, such as pin levels or FIFO status. A further field bit inverts the picked value. The outcome is a condition bit and a writeback enable. An instruction whose condition is false keeps its issue slot, but its result is discarded.

The unit also holds the three status flags. They are loaded from the ALU result bus and the ALU carry-out. Zero is the NOR of every result bit, and sign is the top result bit. The flags load only when the instruction asks for a flag update and its writeback is enabled. The external test bits pass through a two-flop synchronizer before use. Instruction forms that carry no condition field, such as long-literal forms, always execute.

Top module: `pred_cond_unit`

## Requirements
- R1: While reset is asserted, all three flags read 0 and the synchronized external bits read 0, whatever levels are driven on `ext_bits`.
- R2: With `has_cond`=1 and field bit 3 = 0, bits [1:0] select the source as follows: 0 = carry flag, 1 = sign flag, 2 = zero flag, 3 = constant true.
- R3: Field bit 2 = 1 inverts the selected source value before it drives `cond_true`. This applies in both source modes.
- R4: With field bit 3 = 1, bits [1:0] give the index of the synchronized external bit that is used as the source.
- R5: A change on `ext_bits` reaches the condition logic after exactly two rising clock edges, and not after one.
- R6: On a rising edge where `instr_valid`, `sets_flags` and `wb_en` are all 1, the flags load as follows: carry takes `alu_carry`, sign takes the MSB of `alu_result`, and zero is 1 exactly when `alu_result` is all zeros.
- R7: The flags keep their values across an edge when `instr_valid`=0, when `sets_flags`=0, or when the condition is false.
- R8: `wb_en` equals `instr_valid` AND `cond_true`. `cond_true` is evaluated even when no instruction is valid.
- R9: With `has_cond`=0, `cond_true` is 1 whatever the condition field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction occupies the slot this cycle |
| has_cond | input | 1 | The instruction form carries a condition field |
| cond_field | input | 4 | Condition field: bit 3 selects external source, bit 2 inverts, bits [1:0] select |
| sets_flags | input | 1 | The instruction asks for a flag update |
| alu_result | input | RES_W (8) | ALU result bus |
| alu_carry | input | 1 | ALU carry-out |
| ext_bits | input | 4 | Asynchronous external test bits |
| cond_true | output | 1 | Final condition value |
| wb_en | output | 1 | Writeback enable for the current instruction |
| flag_c | output | 1 | Stored carry flag |
| flag_s | output | 1 | Stored sign flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
The assertions assume that `alu_result` and `alu_carry` are stable at each rising edge. They also assume that `rst_n` is held low long enough for the synchronizer to clear. The two-cycle latency property is armed only after two cycles out of reset. The bench changes every input on the falling edge, so each input has half a cycle to settle before the next rising edge. It holds `ext_bits` steady for several cycles before it tests selection of the external bits.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int SEL_W = 2;
    localparam int EXT_N = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_CARRY  = 2'd0,
        SRC_SIGN   = 2'd1,
        SRC_ZERO   = 2'd2,
        SRC_ALWAYS = 2'd3
    } flag_src_e;

    typedef struct packed {
        logic             ext_mode;
        logic             invert;
        logic [SEL_W-1:0] pick;
    } cond_fld_t;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
    } flags_t;

    localparam int FLD_W = $bits(cond_fld_t);

endpackage

// File: rtl/pcu_flag_reg.sv
module pcu_flag_reg
    import pcu_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [RES_W-1:0] result,
    input  logic             carry,
    output flags_t           flags
);
    localparam int MSB = RES_W - 1;

    flags_t nxt;

    always_comb begin
        nxt.c = carry;
        nxt.s = result[MSB];
        nxt.z = ~|result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (upd) begin
            flags <= nxt;
        end
    end

    // A zero result has a clear MSB, so sign and zero are never both set
    p_zs_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags.z |-> !flags.s);
    p_carry_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (flags.c == $past(carry)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags));

endmodule

// File: rtl/pcu_ext_sync.sv
module pcu_ext_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign sync_out = stg[STAGES-1];

    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // While reset is held the output stays clear
    always_comb begin
        if (!rst_n) p_reset_clear_r1: assert (sync_out == '0);
    end

    if (STAGES == 2) begin : g_lat_chk
        p_two_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (warm == 2'd2) |-> (sync_out == $past(async_in, 2)));
    end

endmodule

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
    import pcu_pkg::*;
(
    input  cond_fld_t        fld,
    input  logic             has_cond,
    input  flags_t           flags,
    input  logic [EXT_N-1:0] ext,
    output logic             cond
);
    logic picked;

    always_comb begin
        if (fld.ext_mode) begin
            picked = ext[fld.pick];
        end else begin
            unique case (flag_src_e'(fld.pick))
                SRC_CARRY:  picked = flags.c;
                SRC_SIGN:   picked = flags.s;
                SRC_ZERO:   picked = flags.z;
                SRC_ALWAYS: picked = 1'b1;
            endcase
        end
        cond = has_cond ? (picked ^ fld.invert) : 1'b1;
    end

endmodule

// File: rtl/pred_cond_unit.sv
module pred_cond_unit
    import pcu_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic             has_cond,
    input  logic [3:0]       cond_field,
    input  logic             sets_flags,
    input  logic [RES_W-1:0] alu_result,
    input  logic             alu_carry,
    input  logic [3:0]       ext_bits,
    output logic             cond_true,
    output logic             wb_en,
    output logic             flag_c,
    output logic             flag_s,
    output logic             flag_z
);
    cond_fld_t        fld;
    flags_t           flags;
    logic [EXT_N-1:0] ext_s;
    logic             upd;

    assign fld = cond_fld_t'(cond_field);

    pcu_ext_sync #(.N(EXT_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_bits),
        .sync_out (ext_s)
    );

    pcu_cond_eval u_eval (
        .fld      (fld),
        .has_cond (has_cond),
        .flags    (flags),
        .ext      (ext_s),
        .cond     (cond_true)
    );

    assign wb_en = instr_valid & cond_true;
    assign upd   = wb_en & sets_flags;

    pcu_flag_reg #(.RES_W(RES_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd),
        .result (alu_result),
        .carry  (alu_carry),
        .flags  (flags)
    );

    assign flag_c = flags.c;
    assign flag_s = flags.s;
    assign flag_z = flags.z;

    p_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (has_cond && cond_field == 4'b0011) |-> cond_true);
    p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (has_cond && cond_field == 4'b0111) |-> !cond_true);
    p_wb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (instr_valid && cond_true));
    p_nocond_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !has_cond) |-> wb_en);

endmodule

// File: tb/pred_cond_unit_test.sv
module pred_cond_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic       has_cond = 1'b0;
    logic [3:0] cond_field = 4'h0;
    logic       sets_flags = 1'b0;
    logic [7:0] alu_result = 8'h00;
    logic       alu_carry = 1'b0;
    logic [3:0] ext_bits = 4'h0;
    logic       cond_true, wb_en, flag_c, flag_s, flag_z;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pred_cond_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .has_cond(has_cond),
        .cond_field(cond_field), .sets_flags(sets_flags), .alu_result(alu_result),
        .alu_carry(alu_carry), .ext_bits(ext_bits), .cond_true(cond_true),
        .wb_en(wb_en), .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic hc, input logic [3:0] f,
                         input logic sf, input logic [7:0] res, input logic cy);
        @(negedge clk);
        instr_valid = v; has_cond = hc; cond_field = f;
        sets_flags = sf; alu_result = res; alu_carry = cy;
        #1;
    endtask

    // Load flags through an unconditional flag-setting instruction
    task automatic load_flags(input logic [7:0] res, input logic cy);
        drive(1'b1, 1'b0, 4'b0111, 1'b1, res, cy);
        drive(1'b0, 1'b1, 4'b0000, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic t_reset;
        ext_bits = 4'hF;
        repeat (3) @(negedge clk);
        check("R1 flag_c", flag_c, 0);
        check("R1 flag_s", flag_s, 0);
        check("R1 flag_z", flag_z, 0);
        has_cond = 1'b1; cond_field = 4'b1011; #1;
        check("R1 sync clear", cond_true, 0);
        ext_bits = 4'h0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_capture;
        load_flags(8'h00, 1'b1);
        check("R6 c", flag_c, 1); check("R6 s", flag_s, 0); check("R6 z", flag_z, 1);
        load_flags(8'h80, 1'b0);
        check("R6 c", flag_c, 0); check("R6 s", flag_s, 1); check("R6 z", flag_z, 0);
        load_flags(8'h01, 1'b1);
        check("R6 c", flag_c, 1); check("R6 s", flag_s, 0); check("R6 z", flag_z, 0);
    endtask

    task automatic t_select;
        load_flags(8'h01, 1'b1);
        drive(1'b1, 1'b1, 4'b0000, 1'b0, 8'h00, 1'b0); check("R2 carry", cond_true, 1);
        drive(1'b1, 1'b1, 4'b0001, 1'b0, 8'h00, 1'b0); check("R2 sign", cond_true, 0);
        drive(1'b1, 1'b1, 4'b0010, 1'b0, 8'h00, 1'b0); check("R2 zero", cond_true, 0);
        drive(1'b1, 1'b1, 4'b0011, 1'b0, 8'h00, 1'b0); check("R2 always", cond_true, 1);
        load_flags(8'h80, 1'b0);
        drive(1'b1, 1'b1, 4'b0000, 1'b0, 8'h00, 1'b0); check("R2 carry clr", cond_true, 0);
        drive(1'b1, 1'b1, 4'b0001, 1'b0, 8'h00, 1'b0); check("R2 sign set", cond_true, 1);
    endtask

    task automatic t_invert;
        load_flags(8'h01, 1'b1);
        drive(1'b1, 1'b1, 4'b0100, 1'b0, 8'h00, 1'b0); check("R3 not carry", cond_true, 0);
        drive(1'b1, 1'b1, 4'b0110, 1'b0, 8'h00, 1'b0); check("R3 not zero", cond_true, 1);
        drive(1'b1, 1'b1, 4'b0111, 1'b0, 8'h00, 1'b0); check("R3 never", cond_true, 0);
    endtask

    task automatic t_wb;
        drive(1'b0, 1'b1, 4'b0011, 1'b0, 8'h00, 1'b0);
        check("R8 cond idle", cond_true, 1); check("R8 wb idle", wb_en, 0);
        drive(1'b1, 1'b1, 4'b0111, 1'b0, 8'h00, 1'b0); check("R8 wb false", wb_en, 0);
        drive(1'b1, 1'b1, 4'b0011, 1'b0, 8'h00, 1'b0); check("R8 wb true", wb_en, 1);
    endtask

    task automatic t_hold;
        load_flags(8'h01, 1'b1);   // c=1 s=0 z=0
        drive(1'b1, 1'b1, 4'b0001, 1'b1, 8'h80, 1'b0);   // condition false
        drive(1'b0, 1'b1, 4'b0000, 1'b0, 8'h00, 1'b0);
        check("R7 inhib c", flag_c, 1); check("R7 inhib s", flag_s, 0);
        drive(1'b1, 1'b1, 4'b0011, 1'b0, 8'h00, 1'b0);   // no flag request
        drive(1'b0, 1'b1, 4'b0000, 1'b0, 8'h00, 1'b0);
        check("R7 nosf z", flag_z, 0); check("R7 nosf c", flag_c, 1);
        drive(1'b0, 1'b1, 4'b0011, 1'b1, 8'h00, 1'b0);   // not valid
        drive(1'b0, 1'b1, 4'b0000, 1'b0, 8'h00, 1'b0);
        check("R7 idle z", flag_z, 0); check("R7 idle c", flag_c, 1);
    endtask

    task automatic t_nocond;
        drive(1'b1, 1'b0, 4'b0111, 1'b0, 8'h00, 1'b0);
        check("R9 cond", cond_true, 1); check("R9 wb", wb_en, 1);
        drive(1'b1, 1'b0, 4'b1100, 1'b0, 8'h00, 1'b0);
        check("R9 ext field", cond_true, 1);
    endtask

    task automatic t_ext_latency;
        drive(1'b1, 1'b1, 4'b1010, 1'b0, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        ext_bits = 4'b0100; #1;
        check("R5 before edge", cond_true, 0);
        @(negedge clk); #1;
        check("R5 after one edge", cond_true, 0);
        @(negedge clk); #1;
        check("R5 after two edges", cond_true, 1);
    endtask

    task automatic t_ext_select;
        @(negedge clk); ext_bits = 4'b1010;
        repeat (3) @(negedge clk);
        drive(1'b1, 1'b1, 4'b1000, 1'b0, 8'h00, 1'b0); check("R4 ext0", cond_true, 0);
        drive(1'b1, 1'b1, 4'b1001, 1'b0, 8'h00, 1'b0); check("R4 ext1", cond_true, 1);
        drive(1'b1, 1'b1, 4'b1010, 1'b0, 8'h00, 1'b0); check("R4 ext2", cond_true, 0);
        drive(1'b1, 1'b1, 4'b1011, 1'b0, 8'h00, 1'b0); check("R4 ext3", cond_true, 1);
        drive(1'b1, 1'b1, 4'b1100, 1'b0, 8'h00, 1'b0); check("R3 ext inv", cond_true, 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        t_reset();
        t_capture();
        t_select();
        t_invert();
        t_wb();
        t_hold();
        t_nocond();
        t_ext_latency();
        t_ext_select();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule